// File: doc/BRIEF.md
# Halt Controller with Interrupt Wake-Up

This block governs the halted state of a small CPU core. Once the core executes its halt instruction, the sequencer pulses `halt_req`. From the next cycle onward the controller holds `halt_n` low and raises `force_nop`. The fetch sequencer keeps running ordinary opcode fetch cycles, so memory refresh carries on. The controller tells it to throw away the fetched byte and execute a no-operation in its place.

The interrupt lines are looked at only while the sequencer reports the fourth T-state of a halted fetch (`t4` high at a rising clock edge). A pending non-maskable request always wins. A maskable request needs the enable flip-flop (`ie`) set and is not remembered. One cycle after the qualifying sample the controller leaves halt. It pulses `wake` for one cycle and shows on `ack_kind` which acknowledge cycle the core must run next.

Top module: `halt_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `halt_n`=1, `force_nop`=0, `wake`=0 and `ack_kind`=2'b00.
- R2: `halt_req` high at a rising edge while running makes `halt_n` 0 and `force_nop` 1 from the following cycle. Both hold until the wake-up cycle. `halt_req` seen while already halted has no effect.
- R3: Interrupt lines are sampled only at rising edges where `t4` is 1 while halted. A qualifying request at any other edge does not start a wake-up.
- R4: `int_n` low counts only when `ie` is 1 at the same sample. It is level-sensitive and not latched, so a low `int_n` with `ie`=0 leaves no trace for later samples.
- R5: A falling edge on `nmi_n` (high at one edge, low at the next) creates exactly one pending request. It stays pending until accepted, including a fall that occurs in the sampling cycle itself. Holding `nmi_n` low creates no further request.
- R6: When a non-maskable request and a qualifying maskable request meet at the same sample, the non-maskable one is accepted.
- R7: After an accepting sample edge, the next edge returns `halt_n` to 1 and `force_nop` to 0. For exactly one cycle it sets `wake`=1 and `ack_kind` to 2'b01 (maskable) or 2'b10 (non-maskable). `ack_kind` is 2'b00 otherwise.
- R8: Reset discards any pending non-maskable request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Halt instruction executed (one-cycle strobe) |
| int_n | input | 1 | Maskable interrupt line, active low, level |
| nmi_n | input | 1 | Non-maskable interrupt line, active low, edge |
| ie | input | 1 | Interrupt-enable flip-flop state |
| t4 | input | 1 | Fetch sequencer is in its fourth T-state |
| halt_n | output | 1 | Halted indication, active low |
| force_nop | output | 1 | Discard fetched opcode and execute a no-op |
| wake | output | 1 | One-cycle pulse on leaving halt |
| ack_kind | output | 2 | Acknowledge type for the next cycle: 00 none, 01 maskable, 10 non-maskable |

## Verification
The bench goes after the corner cases of the sampling rules.

- **Maskable request with enable clear:** the request is followed by a sample with the request gone. A design that latched the request would wake up there.
- **Request outside the fourth T-state:** a qualifying request is presented with `t4` low. A design that ignored `t4` would wake a cycle early.
- **Non-maskable fall in the sampling cycle:** the falling edge lands in the same cycle as the sample. A design that only looked at the registered pending bit would miss the wake-up.
- **Held non-maskable line:** `nmi_n` stays low across a second halt. A level-sensitive design would wake again.
- **Both requests together:** a design with the wrong priority would report the maskable type.
- **Reset with a request pending:** a design that kept the pending bit through reset would wake on the first sample afterwards.

// File: rtl/halt_pkg.sv
package halt_pkg;

    localparam int ACK_W = 2;

    typedef enum logic [ACK_W-1:0] {
        ACK_NONE = 2'b00,
        ACK_MASK = 2'b01,
        ACK_NMI  = 2'b10
    } ack_e;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_HALT  = 2'd1,
        HS_LEAVE = 2'd2
    } hstate_e;

    // Non-maskable wins; maskable only when enabled.
    function automatic ack_e pick_ack(input logic nmi_req, input logic mask_ok);
        if (nmi_req)
            return ACK_NMI;
        else if (mask_ok)
            return ACK_MASK;
        else
            return ACK_NONE;
    endfunction

endpackage

// File: rtl/nmi_latch.sv
module nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic clr,
    output logic nmi_req
);
    logic nmi_q;
    logic pend;
    logic fall;

    assign fall    = nmi_q & ~nmi_n;
    assign nmi_req = pend | fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            if (clr)
                pend <= 1'b0;
            else if (fall)
                pend <= 1'b1;
        end
    end

    // R5: a pending bit only appears after a high-to-low step on the pin
    p_pend_from_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(nmi_q) && !$past(nmi_n)));

    // R5: acceptance removes the request
    p_pend_cleared_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend);

endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
    import halt_pkg::*;
(
    input  logic sample_en,
    input  logic nmi_req,
    input  logic int_n,
    input  logic ie,
    output logic accept,
    output ack_e kind
);
    logic mask_ok;

    assign mask_ok = ~int_n & ie;
    assign kind    = sample_en ? pick_ack(nmi_req, mask_ok) : ACK_NONE;
    assign accept  = (kind != ACK_NONE);

    // R6: non-maskable always chosen when present at a sample
    always_comb begin
        if (sample_en && nmi_req)
            p_nmi_priority_r6: assert (kind == ACK_NMI);
    end

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import halt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic t4,
    input  logic accept,
    input  ack_e kind,
    output logic sample_en,
    output logic halt_n,
    output logic force_nop,
    output logic wake,
    output ack_e ack_kind
);
    hstate_e st;
    ack_e    sel_q;
    logic    wake_q;
    ack_e    ack_q;

    assign sample_en = (st == HS_HALT) && t4;
    assign halt_n    = (st == HS_RUN);
    assign force_nop = (st != HS_RUN);
    assign wake      = wake_q;
    assign ack_kind  = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= HS_RUN;
            sel_q  <= ACK_NONE;
            wake_q <= 1'b0;
            ack_q  <= ACK_NONE;
        end else begin
            case (st)
                HS_RUN: begin
                    wake_q <= 1'b0;
                    ack_q  <= ACK_NONE;
                    if (halt_req)
                        st <= HS_HALT;
                end
                HS_HALT: begin
                    if (accept) begin
                        st    <= HS_LEAVE;
                        sel_q <= kind;
                    end
                end
                HS_LEAVE: begin
                    st     <= HS_RUN;
                    wake_q <= 1'b1;
                    ack_q  <= sel_q;
                end
                default: st <= HS_RUN;
            endcase
        end
    end

    // R7: wake is a single-cycle pulse
    p_wake_single_r7: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake);

    // R7: wake only follows a halted cycle and carries a type
    p_wake_from_halt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> (!$past(halt_n) && ack_kind != ACK_NONE));

    // R2: entering halt requires the request
    p_halt_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_n) |-> $past(halt_req));

    // R3: leaving halt requires a T4 sample one cycle earlier
    p_sample_t4_r3: assert property (@(posedge clk) disable iff (rst)
        (st == HS_LEAVE) |-> $past(t4));

    // R7: type output is one-hot or idle
    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_kind));

endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
    import halt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_req,
    input  logic             int_n,
    input  logic             nmi_n,
    input  logic             ie,
    input  logic             t4,
    output logic             halt_n,
    output logic             force_nop,
    output logic             wake,
    output logic [ACK_W-1:0] ack_kind
);
    logic sample_en;
    logic nmi_req;
    logic accept;
    logic clr_nmi;
    ack_e kind;
    ack_e ack_e_out;

    assign clr_nmi  = accept && (kind == ACK_NMI);
    assign ack_kind = ack_e_out;

    nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_n   (nmi_n),
        .clr     (clr_nmi),
        .nmi_req (nmi_req)
    );

    wake_arbiter u_arb (
        .sample_en (sample_en),
        .nmi_req   (nmi_req),
        .int_n     (int_n),
        .ie        (ie),
        .accept    (accept),
        .kind      (kind)
    );

    halt_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .halt_req  (halt_req),
        .t4        (t4),
        .accept    (accept),
        .kind      (kind),
        .sample_en (sample_en),
        .halt_n    (halt_n),
        .force_nop (force_nop),
        .wake      (wake),
        .ack_kind  (ack_e_out)
    );

endmodule

// File: tb/tb_halt_ctrl.sv
module tb_halt_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_req = 1'b0;
    logic       int_n = 1'b1;
    logic       nmi_n = 1'b1;
    logic       ie = 1'b0;
    logic       t4 = 1'b0;
    logic       halt_n;
    logic       force_nop;
    logic       wake;
    logic [1:0] ack_kind;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    halt_ctrl dut (
        .clk(clk), .rst(rst), .halt_req(halt_req), .int_n(int_n),
        .nmi_n(nmi_n), .ie(ie), .t4(t4), .halt_n(halt_n),
        .force_nop(force_nop), .wake(wake), .ack_kind(ack_kind)
    );

    // Row: inputs {halt_req,int_n,nmi_n,ie,t4}, expected {halt_n,force_nop,wake,ack[1:0]}, requirement
    localparam int NV = 22;
    localparam logic [13:0] VECS [0:NV-1] = '{
        {5'b01100, 5'b10000, 4'd1},  // R1 idle after reset
        {5'b11100, 5'b01000, 4'd2},  // R2 enter halt
        {5'b00101, 5'b01000, 4'd4},  // R4 int low, ie clear, at T4
        {5'b01111, 5'b01000, 4'd4},  // R4 int gone, ie set: nothing latched
        {5'b00110, 5'b01000, 4'd3},  // R3 qualifying int but not T4
        {5'b00111, 5'b01000, 4'd3},  // R3 accepted at T4, still halted
        {5'b01110, 5'b10101, 4'd7},  // R7 wake with maskable type
        {5'b01100, 5'b10000, 4'd7},  // R7 pulse over
        {5'b11100, 5'b01000, 4'd2},  // R2 halt again
        {5'b01000, 5'b01000, 4'd5},  // R5 nmi fall outside T4 -> pending
        {5'b00011, 5'b01000, 4'd6},  // R6 both at T4
        {5'b01100, 5'b10110, 4'd6},  // R6 non-maskable chosen
        {5'b01100, 5'b10000, 4'd7},  // R7 pulse over
        {5'b11100, 5'b01000, 4'd2},  // R2 halt again
        {5'b01101, 5'b01000, 4'd5},  // R5 pending was consumed
        {5'b01001, 5'b01000, 4'd5},  // R5 fall in sampling cycle
        {5'b01000, 5'b10110, 4'd7},  // R7 wake non-maskable
        {5'b01000, 5'b10000, 4'd7},  // R7 pulse over
        {5'b11000, 5'b01000, 4'd2},  // R2 halt with nmi held low
        {5'b01001, 5'b01000, 4'd5},  // R5 held level: no request
        {5'b01101, 5'b01000, 4'd5},  // R5 rising: no request
        {5'b11101, 5'b01000, 4'd2}   // R2 halt_req while halted ignored
    };

    task automatic expect_out(input logic [4:0] exp, input int req, input string what);
        checks++;
        if ({halt_n, force_nop, wake, ack_kind} !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got halt_n=%b nop=%b wake=%b ack=%b, expected %b",
                     req, what, halt_n, force_nop, wake, ack_kind, exp);
        end
    endtask

    task automatic drive(input logic [4:0] v);
        {halt_req, int_n, nmi_n, ie, t4} = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_out(5'b10000, 1, "reset state");  // R1
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i][13:9]);
            expect_out(VECS[i][8:4], int'(VECS[i][3:0]), $sformatf("vector %0d", i));
        end
        // Directed: NMI pending, then reset (R8, R1)
        drive(5'b01000);                          // fall while halted, no T4
        expect_out(5'b01000, 5, "pending before reset");
        rst = 1'b1;
        drive(5'b01100);
        expect_out(5'b10000, 1, "reset leaves halt");  // R1
        rst = 1'b0;
        drive(5'b11100);
        expect_out(5'b01000, 2, "halt after reset");
        drive(5'b01101);
        expect_out(5'b01000, 8, "pending dropped by reset");  // R8
        drive(5'b01101);
        expect_out(5'b01000, 8, "still halted");  // R8
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule